// File: doc/BRIEF.md
# Eight-Bit Dual-Compare Timer with Pin Actions

This block is an eight-bit up-counter behind a byte-wide register port. A clock selector picks what advances the counter: one of three internal prescaled rates, a pulse input from a neighbouring counter's overflow (so two timers can be chained), or nothing at all. Two compare registers are checked against the counter on every count step. A match raises a status flag and, when enabled, an interrupt. It can also clear the counter and change the level of a single output pin through a two-bit action per compare register.

The counter can also be cleared by the rising edge of an external pin. Wrapping from 0xFF to 0x00 raises an overflow flag and sends out a one-clock overflow pulse for the next timer in a chain. Match A can also issue a one-clock conversion trigger. Software clears a flag by reading it as 1 and then writing 0 to it.

Register map (`bus_addr`): 0 control, 1 status, 2 compare A, 3 compare B, 4 counter. Reads return data in the cycle after `bus_rd` is sampled.

Top module: `byte_timer`

## Requirements
- R1: Control bits [2:0] pick the count source: 000 stopped, 001 one step per 8 clocks, 010 one step per 64 clocks, 011 one step per 8192 clocks (each step on the falling edge of the divided clock), 100 chained, 101 to 111 stopped. A stopped counter keeps its value.
- R2: In chained mode the counter advances by exactly one for every clock cycle in which `chain_tick` is high.
- R3: Control bits [4:3] pick the clear source: 00 none, 01 match A, 10 match B, 11 external pin. A match clear loads 0 instead of incrementing, so the period is the compare value plus one steps.
- R4: With clear source 11, a rising edge on `ext_clr` zeroes the counter; a level held high clears once. With any other clear source the pin has no effect.
- R5: A match is a count step taken while the counter equals a compare register. It sets status bit 6 (A) or bit 7 (B). Control bit 6 gates `irq_match_a`, bit 7 gates `irq_match_b` and bit 5 gates `irq_ovf`.
- R6: A count step from 0xFF that is not a match clear wraps to 0x00, sets status bit 5 and gives a one-clock pulse on `ovf_out`.
- R7: Status bits [1:0] set the pin action on match A and bits [3:2] on match B: 00 hold, 01 drive 0, 10 drive 1, 11 invert. The pin changes on the clock edge of the match and at no other time.
- R8: When both matches fall on the same step, a non-hold B action is applied and the A action is dropped. If the B action is hold, the A action applies. Two inverts give a single inversion.
- R9: When status bit 4 is 1, each match A gives a one-clock pulse on `adc_trig`. When the bit is 0 there is no pulse.
- R10: A flag clears only when status is written with that bit 0 after a read that returned the bit as 1. Writing 0 without such a read leaves the flag set, and a new set wins over a clear in the same cycle.
- R11: Reset zeroes every register and drives `cmp_pin`, the interrupts and the pulse outputs to 0.
- R12: Control, compare A, compare B and the counter read back what was written. A write to the counter takes priority over counting and clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| bus_wr | input | 1 | register write strobe |
| bus_rd | input | 1 | register read strobe |
| bus_addr | input | 3 | register index |
| bus_wdata | input | 8 | write data |
| bus_rdata | output | 8 | read data, one cycle after the strobe |
| chain_tick | input | 1 | overflow pulse from the companion counter |
| ext_clr | input | 1 | external counter clear pin |
| cmp_pin | output | 1 | compare output pin |
| irq_match_a | output | 1 | match A interrupt |
| irq_match_b | output | 1 | match B interrupt |
| irq_ovf | output | 1 | overflow interrupt |
| adc_trig | output | 1 | conversion trigger pulse |
| ovf_out | output | 1 | overflow pulse for cascading |

## Verification
The two compare units can hit on the same count step, and both then act on the one output pin. The bench sets both compare registers to the same value and steps the counter onto it with the chained input. It then reads the pin directly after that edge for several action pairs: B drive against A drive, both invert, and B hold with A invert. Each result is judged against the priority rule. A second overlap, a hardware flag set against a software clear, is covered by an assertion.

// File: rtl/byte_timer_pkg.sv
package byte_timer_pkg;
  typedef enum logic [1:0] {
    CLR_NONE    = 2'b00,
    CLR_MATCH_A = 2'b01,
    CLR_MATCH_B = 2'b10,
    CLR_PIN     = 2'b11
  } clr_mode_e;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_FLIP = 2'b11
  } pin_act_e;

  localparam logic [2:0] SEL_STOP  = 3'b000;
  localparam logic [2:0] SEL_DIV_A = 3'b001;
  localparam logic [2:0] SEL_DIV_B = 3'b010;
  localparam logic [2:0] SEL_DIV_C = 3'b011;
  localparam logic [2:0] SEL_CHAIN = 3'b100;

  localparam logic [2:0] REG_CTL  = 3'd0;
  localparam logic [2:0] REG_STS  = 3'd1;
  localparam logic [2:0] REG_CMPA = 3'd2;
  localparam logic [2:0] REG_CMPB = 3'd3;
  localparam logic [2:0] REG_CNT  = 3'd4;

  localparam int NUM_FLAGS = 3;
endpackage

// File: rtl/byte_timer_presc.sv
module byte_timer_presc
  import byte_timer_pkg::*;
#(
  parameter int DIV_A_LOG2 = 3,
  parameter int DIV_B_LOG2 = 6,
  parameter int DIV_C_LOG2 = 13
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel,
  input  logic       chain_tick,
  output logic       step
);
  localparam int PW = DIV_C_LOG2;
  localparam int NTAP = 3;
  localparam int TAP_LOG2 [NTAP] = '{DIV_A_LOG2, DIV_B_LOG2, DIV_C_LOG2};

  logic [PW-1:0]   pre_q;
  logic [NTAP-1:0] taps;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  // The divided clock's top bit falls on the cycle after its low bits are all ones.
  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    assign taps[i] = &pre_q[TAP_LOG2[i]-1:0];
  end

  always_comb begin
    case (sel)
      SEL_DIV_A: step = taps[0];
      SEL_DIV_B: step = taps[1];
      SEL_DIV_C: step = taps[2];
      SEL_CHAIN: step = chain_tick;
      default:   step = 1'b0;
    endcase
  end
endmodule

// File: rtl/byte_timer_pin.sv
module byte_timer_pin
  import byte_timer_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     hit_a,
  input  logic     hit_b,
  input  pin_act_e act_a,
  input  pin_act_e act_b,
  output logic     pin
);
  pin_act_e eff;

  always_comb begin
    eff = ACT_HOLD;
    if (hit_a) eff = act_a;
    if (hit_b && act_b != ACT_HOLD) eff = act_b;
  end

  always_ff @(posedge clk) begin
    if (rst) pin <= 1'b0;
    else begin
      case (eff)
        ACT_LOW:  pin <= 1'b0;
        ACT_HIGH: pin <= 1'b1;
        ACT_FLIP: pin <= ~pin;
        default:  pin <= pin;
      endcase
    end
  end
endmodule

// File: rtl/byte_timer_flag.sv
module byte_timer_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic rd_hit,
  input  logic wr_zero,
  output logic flag
);
  logic armed_q;
  logic do_clr;

  assign do_clr = wr_zero && armed_q && !set;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (set)         flag <= 1'b1;
      else if (do_clr) flag <= 1'b0;
      if (do_clr)                armed_q <= 1'b0;
      else if (rd_hit && flag)   armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/byte_timer.sv
module byte_timer
  import byte_timer_pkg::*;
#(
  parameter int DW         = 8,
  parameter int AW         = 3,
  parameter int DIV_A_LOG2 = 3,
  parameter int DIV_B_LOG2 = 6,
  parameter int DIV_C_LOG2 = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          chain_tick,
  input  logic          ext_clr,
  output logic          cmp_pin,
  output logic          irq_match_a,
  output logic          irq_match_b,
  output logic          irq_ovf,
  output logic          adc_trig,
  output logic          ovf_out
);
  localparam int CFGW = 5;

  logic [DW-1:0]        ctl_q, cmp_a_q, cmp_b_q, cnt_q;
  logic [CFGW-1:0]      cfg_q;
  logic                 ext_q;
  logic                 step, hit_a, hit_b, match_clr, wrap, ext_edge;
  logic                 wr_ctl, wr_sts, wr_cmpa, wr_cmpb, wr_cnt, rd_sts;
  logic [NUM_FLAGS-1:0] flag_v, set_v;
  clr_mode_e            clr_mode;

  assign clr_mode = clr_mode_e'(ctl_q[4:3]);
  assign wr_ctl  = bus_wr && bus_addr == REG_CTL;
  assign wr_sts  = bus_wr && bus_addr == REG_STS;
  assign wr_cmpa = bus_wr && bus_addr == REG_CMPA;
  assign wr_cmpb = bus_wr && bus_addr == REG_CMPB;
  assign wr_cnt  = bus_wr && bus_addr == REG_CNT;
  assign rd_sts  = bus_rd && bus_addr == REG_STS;

  byte_timer_presc #(
    .DIV_A_LOG2(DIV_A_LOG2),
    .DIV_B_LOG2(DIV_B_LOG2),
    .DIV_C_LOG2(DIV_C_LOG2)
  ) u_presc (
    .clk(clk), .rst(rst), .sel(ctl_q[2:0]), .chain_tick(chain_tick), .step(step)
  );

  assign hit_a     = step && cnt_q == cmp_a_q;
  assign hit_b     = step && cnt_q == cmp_b_q;
  assign match_clr = (clr_mode == CLR_MATCH_A && hit_a) || (clr_mode == CLR_MATCH_B && hit_b);
  assign wrap      = step && !match_clr && (&cnt_q);
  assign ext_edge  = clr_mode == CLR_PIN && ext_clr && !ext_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '0;
      cmp_a_q <= '0;
      cmp_b_q <= '0;
      cfg_q   <= '0;
      cnt_q   <= '0;
      ext_q   <= 1'b0;
    end else begin
      ext_q <= ext_clr;
      if (wr_ctl)  ctl_q   <= bus_wdata;
      if (wr_cmpa) cmp_a_q <= bus_wdata;
      if (wr_cmpb) cmp_b_q <= bus_wdata;
      if (wr_sts)  cfg_q   <= bus_wdata[CFGW-1:0];
      if (wr_cnt)        cnt_q <= bus_wdata;
      else if (ext_edge) cnt_q <= '0;
      else if (step)     cnt_q <= match_clr ? '0 : cnt_q + 1'b1;
    end
  end

  // Flag order: 0 overflow (status bit 5), 1 match A (bit 6), 2 match B (bit 7).
  assign set_v = {hit_b, hit_a, wrap};
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    byte_timer_flag u_flag (
      .clk(clk), .rst(rst), .set(set_v[i]), .rd_hit(rd_sts),
      .wr_zero(wr_sts && !bus_wdata[CFGW+i]), .flag(flag_v[i])
    );
  end

  byte_timer_pin u_pin (
    .clk(clk), .rst(rst), .hit_a(hit_a), .hit_b(hit_b),
    .act_a(pin_act_e'(cfg_q[1:0])), .act_b(pin_act_e'(cfg_q[3:2])), .pin(cmp_pin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      adc_trig  <= 1'b0;
      ovf_out   <= 1'b0;
    end else begin
      adc_trig <= hit_a && cfg_q[4];
      ovf_out  <= wrap;
      if (bus_rd) begin
        case (bus_addr)
          REG_CTL:  bus_rdata <= ctl_q;
          REG_STS:  bus_rdata <= {flag_v, cfg_q};
          REG_CMPA: bus_rdata <= cmp_a_q;
          REG_CMPB: bus_rdata <= cmp_b_q;
          REG_CNT:  bus_rdata <= cnt_q;
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end

  assign irq_ovf     = flag_v[0] && ctl_q[5];
  assign irq_match_a = flag_v[1] && ctl_q[6];
  assign irq_match_b = flag_v[2] && ctl_q[7];
endmodule

// File: rtl/byte_timer_chk.sv
module byte_timer_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_wr,
  input logic [2:0]    bus_addr,
  input logic [DW-1:0] cnt_q,
  input logic [DW-1:0] cmp_a_q,
  input logic [DW-1:0] ctl_q,
  input logic [2:0]    flag_v,
  input logic          hit_a,
  input logic          hit_b,
  input logic          cmp_pin,
  input logic          adc_trig,
  input logic          ovf_out
);
  assert_pin_reset_R11: assert property (@(posedge clk) $past(rst) |-> !cmp_pin && !adc_trig && !ovf_out);

  assert_adc_on_match_R9: assert property (@(posedge clk) disable iff (rst)
    adc_trig |-> $past(cnt_q) == $past(cmp_a_q));

  assert_ovf_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    ovf_out |-> $past(cnt_q) == {DW{1'b1}});

  assert_ovf_flag_source_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_v[0]) |-> $past(cnt_q) == {DW{1'b1}});

  assert_stop_holds_R1: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[2:0] == 3'b000 && ctl_q[4:3] != 2'b11 && !bus_wr) |=> $stable(cnt_q));

  assert_flag_clear_by_write_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_v[1]) |-> $past(bus_wr) && $past(bus_addr) == 3'd1 && !$past(hit_a));

  assert_pin_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !(hit_a || hit_b) |=> $stable(cmp_pin));
endmodule

bind byte_timer byte_timer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .cnt_q(cnt_q),
  .cmp_a_q(cmp_a_q), .ctl_q(ctl_q), .flag_v(flag_v), .hit_a(hit_a), .hit_b(hit_b),
  .cmp_pin(cmp_pin), .adc_trig(adc_trig), .ovf_out(ovf_out)
);

// File: tb/byte_timer_tb.sv
module byte_timer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       chain_tick = 1'b0, ext_clr = 1'b0;
  logic       cmp_pin, irq_match_a, irq_match_b, irq_ovf, adc_trig, ovf_out;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  byte_timer u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chain_tick(chain_tick),
    .ext_clr(ext_clr), .cmp_pin(cmp_pin), .irq_match_a(irq_match_a),
    .irq_match_b(irq_match_b), .irq_ovf(irq_ovf), .adc_trig(adc_trig), .ovf_out(ovf_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic tick(input int n);
    chain_tick = 1'b1;
    repeat (n) @(negedge clk);
    chain_tick = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      chk(d == 8'h00, "R11 register zero", d, 0);
    end
    chk({cmp_pin, irq_match_a, irq_match_b, irq_ovf, adc_trig, ovf_out} == 6'b0, "R11 outputs zero",
        {cmp_pin, irq_match_a, irq_match_b, irq_ovf, adc_trig, ovf_out}, 0);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wr(3'd2, 8'h5A); rd(3'd2, d); chk(d == 8'h5A, "R12 compare A", d, 8'h5A);
    wr(3'd3, 8'hA5); rd(3'd3, d); chk(d == 8'hA5, "R12 compare B", d, 8'hA5);
    wr(3'd0, 8'h07); rd(3'd0, d); chk(d == 8'h07, "R12 control", d, 8'h07);
    wr(3'd4, 8'h33); tick(6); repeat (20) @(negedge clk);
    rd(3'd4, d); chk(d == 8'h33, "R1 select 111 keeps count", d, 8'h33);
    wr(3'd0, 8'h00); tick(6); rd(3'd4, d); chk(d == 8'h33, "R1 stopped keeps count", d, 8'h33);
  endtask

  task automatic t_chain;
    logic [7:0] d;
    wr(3'd0, 8'h04); wr(3'd4, 8'h00); tick(7);
    rd(3'd4, d); chk(d == 8'd7, "R2 chained count", d, 7);
  endtask

  task automatic t_match;
    logic [7:0] d;
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h06);              // A drive 1, B drive 0
    wr(3'd2, 8'd2); wr(3'd3, 8'd4);
    wr(3'd4, 8'd0); wr(3'd0, 8'h44);
    tick(3);
    chk(cmp_pin == 1'b1, "R7 match A drives 1", cmp_pin, 1);
    chk(irq_match_a == 1'b1, "R5 irq A", irq_match_a, 1);
    tick(2);
    chk(cmp_pin == 1'b0, "R7 match B drives 0", cmp_pin, 0);
    chk(irq_match_b == 1'b0, "R5 irq B masked", irq_match_b, 0);
    rd(3'd1, d); chk(d[7:6] == 2'b11, "R5 match flags", d[7:6], 3);
  endtask

  task automatic t_ovf_flags;
    logic [7:0] d;
    wr(3'd0, 8'h24); wr(3'd2, 8'h10); wr(3'd3, 8'h20); wr(3'd4, 8'hFE);
    tick(1);
    chk(irq_ovf == 1'b0, "R6 no flag before wrap", irq_ovf, 0);
    tick(1);
    chk(ovf_out == 1'b1, "R6 overflow pulse", ovf_out, 1);
    chk(irq_ovf == 1'b1, "R6 overflow irq", irq_ovf, 1);
    @(negedge clk);
    chk(ovf_out == 1'b0, "R6 pulse one clock", ovf_out, 0);
    rd(3'd4, d); chk(d == 8'h00, "R6 wrapped to zero", d, 0);
    wr(3'd0, 8'h20);
    wr(3'd1, 8'h06);
    chk(irq_ovf == 1'b1, "R10 write without read keeps flag", irq_ovf, 1);
    rd(3'd1, d); wr(3'd1, 8'h06);
    chk(irq_ovf == 1'b0, "R10 read then write clears", irq_ovf, 0);
    rd(3'd1, d); chk(d[5] == 1'b0, "R10 flag bit zero", d[5], 0);
  endtask

  task automatic t_same;
    wr(3'd0, 8'h04); wr(3'd2, 8'd3); wr(3'd3, 8'd3);
    wr(3'd1, 8'h09);              // A drive 0, B drive 1
    wr(3'd4, 8'd0); tick(4);
    chk(cmp_pin == 1'b1, "R8 B drive wins", cmp_pin, 1);
    wr(3'd1, 8'h0F);              // both invert
    wr(3'd4, 8'd0); tick(4);
    chk(cmp_pin == 1'b0, "R8 double invert once", cmp_pin, 0);
    wr(3'd1, 8'h03);              // A invert, B hold
    wr(3'd4, 8'd0); tick(4);
    chk(cmp_pin == 1'b1, "R8 B hold lets A act", cmp_pin, 1);
  endtask

  task automatic t_clear;
    logic [7:0] d;
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h14); wr(3'd3, 8'd2); wr(3'd2, 8'h80); wr(3'd4, 8'd0);
    tick(3); rd(3'd4, d); chk(d == 8'd0, "R3 clear on B", d, 0);
    tick(2); rd(3'd4, d); chk(d == 8'd2, "R3 counts after clear", d, 2);
    wr(3'd0, 8'h0C); wr(3'd2, 8'd1); wr(3'd4, 8'd0);
    tick(2); rd(3'd4, d); chk(d == 8'd0, "R3 clear on A", d, 0);
  endtask

  task automatic t_ext;
    logic [7:0] d;
    wr(3'd0, 8'h00); wr(3'd4, 8'h40);
    ext_clr = 1'b1; repeat (2) @(negedge clk); ext_clr = 1'b0; @(negedge clk);
    rd(3'd4, d); chk(d == 8'h40, "R4 pin ignored", d, 8'h40);
    wr(3'd0, 8'h18);
    ext_clr = 1'b1; repeat (2) @(negedge clk);
    rd(3'd4, d); chk(d == 8'h00, "R4 pin edge clears", d, 0);
    wr(3'd4, 8'h22); repeat (3) @(negedge clk);
    rd(3'd4, d); chk(d == 8'h22, "R4 held level clears once", d, 8'h22);
    ext_clr = 1'b0;
  endtask

  task automatic t_adc;
    wr(3'd0, 8'h04); wr(3'd1, 8'h10); wr(3'd2, 8'd2); wr(3'd3, 8'h90); wr(3'd4, 8'd0);
    tick(3);
    chk(adc_trig == 1'b1, "R9 trigger on match A", adc_trig, 1);
    @(negedge clk);
    chk(adc_trig == 1'b0, "R9 trigger one clock", adc_trig, 0);
    wr(3'd1, 8'h00); wr(3'd4, 8'd0); tick(3);
    chk(adc_trig == 1'b0, "R9 disabled no trigger", adc_trig, 0);
  endtask

  task automatic rate(input logic [7:0] c, input logic [7:0] cmpa, input int exp, input string req);
    int n;
    wr(3'd1, 8'h10); wr(3'd2, cmpa); wr(3'd0, c);
    while (!adc_trig) @(negedge clk);
    n = 0;
    @(negedge clk);
    while (!adc_trig && n < 20000) begin n++; @(negedge clk); end
    chk(n + 1 == exp, req, n + 1, exp);
  endtask

  task automatic t_rate;
    rate(8'h09, 8'd3, 32,   "R1 divide by 8");
    rate(8'h0A, 8'd3, 256,  "R1 divide by 64");
    rate(8'h0B, 8'd0, 8192, "R1 divide by 8192");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset(); t_regs(); t_chain(); t_match(); t_ovf_flags();
        t_same(); t_clear(); t_ext(); t_adc(); t_rate();
      end
      begin
        repeat (200000) @(negedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule